// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers a parameterised set of interrupt request lines (64 by default) and presents the single most urgent one to a processor. The processor sees two things: one interrupt line, and a vector number that names the chosen source. Each source has its own configuration word. That word picks edge or level sensitivity and holds a priority level. Software controls each source's enable with separate write-one-to-set and write-one-to-clear registers, one pair per group of 32 sources.

Software works the block through a 32-bit register port. Writes take effect in a single cycle, and read data appears one cycle after the read strobe. A global generation enable gates the processor interrupt. A write-only end-of-interrupt register retires the latched edge of the source currently presented. A soft reset register returns every register to its power-up value. When no enabled source is pending, the vector reads as the number of sources, and software treats that value as spurious.

Top module: `vic64_ctrl`

## Requirements
- R1: After `rst_n` is released, every source is disabled, level-sensitive and at priority 0, generation is off, `cpu_irq` is 0, `cpu_vec` is 64, and every register reads 0 except the vector register, which reads 64.
- R2: A write to an enable register (byte address 0x000 for sources 0–31, 0x008 for sources 32–63) sets the enable of every source whose bit is 1 and leaves the other enables unchanged. A read of that address, or of the matching disable address, returns the current enable mask of that group.
- R3: A write to a disable register (byte address 0x020 for sources 0–31, 0x028 for sources 32–63) clears the enable of every source whose bit is 1 and leaves the other enables unchanged.
- R4: A level-sensitive source is pending exactly while its sampled input is high. It stops being pending once the input falls, and no end-of-interrupt write is needed.
- R5: An edge-sensitive source latches a rising edge of its input into a pending flag. The flag stays set after the input falls.
- R6: Among the enabled, pending sources, `cpu_vec` names the one with the highest priority, taken from bits [PRIO_W-1:0] of the setup word at byte address 0x400 + n*8. On equal priority the lowest source number wins. The setup word reads back as written, with bit 16 holding the edge select.
- R7: `cpu_irq` is high only when the generation enable (bit 0 of byte address 0x058) was set and a valid selection existed. While generation is off, `cpu_vec` still tracks the selection.
- R8: When no enabled source is pending, `cpu_vec` is 64. A read of the vector register (byte address 0x040) returns, one cycle later, the value `cpu_vec` held at the read strobe.
- R9: A write to the end-of-interrupt register (byte address 0x048) clears the latched edge of the source that `cpu_vec` names at that moment.
- R10: A setup write with bit 16 at 0 clears that source's latched edge. Restoring edge mode afterwards leaves the latch clear.
- R11: A write with bit 0 set to the soft reset register (byte address 0x050) returns the whole block to the R1 state on the next cycle.
- R12: A rising edge that arrives in the same cycle as a clear of that source's latch keeps the latch set.
- R13: An edge latched while its source is disabled is held, and it is presented once the source is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NUM_SRC | Interrupt request lines, synchronous to clk |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address; accesses with bits [2:0] nonzero are ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read strobe, 0 otherwise |
| cpu_irq | output | 1 | Interrupt request to the processor |
| cpu_vec | output | $clog2(NUM_SRC+1) | Selected source number, or NUM_SRC when none |

## Verification
The selection logic is exercised with several patterns. A lone level source separates the generation gate from the vector path. Three simultaneous sources at different priorities show that priority outranks source number. A later raise of a top-priority source shows that the selection moves. Two sources at equal priority expose the direction of tie-breaking. Edge sources are exercised with single-cycle pulses, including pulses that arrive while the source is disabled and pulses that coincide with an end-of-interrupt write, which separates set-wins from clear-wins.

// File: rtl/vic_pkg.sv
package vic_pkg;

   localparam int unsigned DATA_W   = 32;
   localparam int unsigned GRP_SZ   = 32;
   localparam int unsigned EDGE_BIT = 16;

   // word index (byte address >> 3) inside the control region
   localparam int unsigned WI_ENA = 0;
   localparam int unsigned WI_DIS = 4;
   localparam int unsigned WI_VEC = 8;
   localparam int unsigned WI_EOI = 9;
   localparam int unsigned WI_RST = 10;
   localparam int unsigned WI_GEN = 11;

   typedef struct packed {
      logic ena;
      logic dis;
      logic eoi;
      logic rst;
      logic gen;
      logic setup;
   } wr_strobe_t;

   typedef enum logic [2:0] {
      RD_NONE,
      RD_ENA,
      RD_VEC,
      RD_GEN,
      RD_SETUP
   } rd_kind_t;

endpackage

// File: rtl/vic_regif.sv
module vic_regif
   import vic_pkg::*;
#(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned PRIO_W  = 4,
   parameter int unsigned ADDR_W  = 11,
   parameter int unsigned VEC_W   = 7,
   parameter int unsigned IDX_W   = 7
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sel,
   input  logic                      we,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [NUM_SRC-1:0]        en_mask,
   input  logic [NUM_SRC-1:0]        edge_mode,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
   input  logic [VEC_W-1:0]          cur_vec,
   input  logic                      gen_en,
   output wr_strobe_t                wr,
   output logic [1:0]                wr_grp,
   output logic [IDX_W-1:0]          setup_idx,
   output logic [DATA_W-1:0]         rdata
);

   localparam int unsigned NUM_GRP = NUM_SRC / GRP_SZ;

   logic              aligned;
   logic              in_setup;
   logic              low_ok;
   logic [3:0]        word;
   rd_kind_t          kind;
   logic [DATA_W-1:0] rd_val;

   assign aligned   = (addr[2:0] == 3'b000);
   assign in_setup  = addr[ADDR_W-1];
   assign low_ok    = (addr[ADDR_W-2:7] == '0);
   assign word      = addr[6:3];
   assign setup_idx = addr[ADDR_W-2:3];

   always_comb begin
      wr     = '0;
      wr_grp = 2'd0;
      kind   = RD_NONE;
      if (sel && aligned) begin
         if (in_setup) begin
            kind     = RD_SETUP;
            wr.setup = we;
         end else if (low_ok) begin
            if (word < 4'(WI_DIS)) begin
               wr_grp = word[1:0];
               if (32'(word[1:0]) < NUM_GRP) begin
                  kind   = RD_ENA;
                  wr.ena = we;
               end
            end else if (word < 4'(WI_VEC)) begin
               wr_grp = word[1:0];
               if (32'(word[1:0]) < NUM_GRP) begin
                  kind   = RD_ENA;
                  wr.dis = we;
               end
            end else if (word == 4'(WI_VEC)) begin
               kind = RD_VEC;
            end else if (word == 4'(WI_EOI)) begin
               wr.eoi = we;
            end else if (word == 4'(WI_RST)) begin
               wr.rst = we;
            end else if (word == 4'(WI_GEN)) begin
               kind   = RD_GEN;
               wr.gen = we;
            end
         end
      end
   end

   always_comb begin
      rd_val = '0;
      case (kind)
         RD_ENA: begin
            for (int g = 0; g < int'(NUM_GRP); g++) begin
               if (wr_grp == 2'(g)) rd_val = en_mask[g*GRP_SZ +: GRP_SZ];
            end
         end
         RD_VEC:  rd_val = DATA_W'(cur_vec);
         RD_GEN:  rd_val = DATA_W'(gen_en);
         RD_SETUP: begin
            for (int i = 0; i < int'(NUM_SRC); i++) begin
               if (setup_idx == IDX_W'(i)) begin
                  rd_val = DATA_W'(prio_flat[i*PRIO_W +: PRIO_W])
                         | (DATA_W'(edge_mode[i]) << EDGE_BIT);
               end
            end
         end
         default: rd_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= (sel && !we) ? rd_val : '0;
   end

endmodule

// File: rtl/vic_src_bank.sv
module vic_src_bank
   import vic_pkg::*;
#(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned PRIO_W  = 4,
   parameter int unsigned VEC_W   = 7,
   parameter int unsigned IDX_W   = 7
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr_all,
   input  logic [NUM_SRC-1:0]        irq_src,
   input  logic                      ena_wr,
   input  logic                      dis_wr,
   input  logic                      eoi_wr,
   input  logic                      setup_wr,
   input  logic [1:0]                wr_grp,
   input  logic [IDX_W-1:0]          setup_idx,
   input  logic [DATA_W-1:0]         wdata,
   input  logic [VEC_W-1:0]          cur_vec,
   output logic [NUM_SRC-1:0]        en_mask,
   output logic [NUM_SRC-1:0]        edge_mode,
   output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
   output logic [NUM_SRC-1:0]        pend
);

   for (genvar i = 0; i < int'(NUM_SRC); i++) begin : g_src
      localparam int G = i / int'(GRP_SZ);
      localparam int B = i % int'(GRP_SZ);

      logic              en_q;
      logic              edge_q;
      logic              lat_q;
      logic              smp_q;
      logic [PRIO_W-1:0] prio_q;
      logic              hit;
      logic              rise;
      logic              kill;

      assign hit  = setup_wr && (setup_idx == IDX_W'(i));
      assign rise = edge_q && irq_src[i] && !smp_q;
      assign kill = (eoi_wr && (cur_vec == VEC_W'(i)))
                 || (hit && !wdata[EDGE_BIT]);

      always_ff @(posedge clk) begin
         if (!rst_n || clr_all) begin
            en_q   <= 1'b0;
            edge_q <= 1'b0;
            lat_q  <= 1'b0;
            smp_q  <= 1'b0;
            prio_q <= '0;
         end else begin
            smp_q <= irq_src[i];
            if (ena_wr && wr_grp == 2'(G) && wdata[B])      en_q <= 1'b1;
            else if (dis_wr && wr_grp == 2'(G) && wdata[B]) en_q <= 1'b0;
            if (hit) begin
               edge_q <= wdata[EDGE_BIT];
               prio_q <= wdata[PRIO_W-1:0];
            end
            lat_q <= rise || (lat_q && !kill);
         end
      end

      assign en_mask[i]                     = en_q;
      assign edge_mode[i]                   = edge_q;
      assign prio_flat[i*PRIO_W +: PRIO_W]  = prio_q;
      assign pend[i]                        = edge_q ? lat_q : smp_q;
   end

endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned PRIO_W  = 4,
   parameter int unsigned VEC_W   = 7
) (
   input  logic [NUM_SRC-1:0]        req,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
   output logic [VEC_W-1:0]          vec,
   output logic                      valid
);

   logic [PRIO_W-1:0] best_p;

   // descending scan with >= so that the lowest number wins a tie
   always_comb begin
      vec    = VEC_W'(NUM_SRC);
      valid  = 1'b0;
      best_p = '0;
      for (int i = int'(NUM_SRC) - 1; i >= 0; i--) begin
         if (req[i] && (!valid || prio_flat[i*PRIO_W +: PRIO_W] >= best_p)) begin
            vec    = VEC_W'(i);
            best_p = prio_flat[i*PRIO_W +: PRIO_W];
            valid  = 1'b1;
         end
      end
   end

endmodule

// File: rtl/vic64_ctrl.sv
module vic64_ctrl
   import vic_pkg::*;
#(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned PRIO_W  = 4,
   parameter int unsigned ADDR_W  = 11,
   localparam int unsigned VEC_W  = $clog2(NUM_SRC + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SRC-1:0]   irq_src,
   input  logic                 reg_sel,
   input  logic                 reg_we,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   output logic                 cpu_irq,
   output logic [VEC_W-1:0]     cpu_vec
);

   localparam int unsigned IDX_W = ADDR_W - 4;

   if (NUM_SRC % GRP_SZ != 0 || NUM_SRC < GRP_SZ || NUM_SRC > 4 * GRP_SZ) begin : g_bad_src
      $error("NUM_SRC must be a multiple of 32 between 32 and 128");
   end
   if (PRIO_W < 1 || PRIO_W > EDGE_BIT) begin : g_bad_prio
      $error("PRIO_W must lie between 1 and 16");
   end
   if (ADDR_W < 9 || IDX_W < $clog2(NUM_SRC)) begin : g_bad_addr
      $error("ADDR_W too small for the setup region");
   end

   wr_strobe_t                wr;
   logic [1:0]                wr_grp;
   logic [IDX_W-1:0]          setup_idx;
   logic [NUM_SRC-1:0]        en_mask;
   logic [NUM_SRC-1:0]        edge_mode;
   logic [NUM_SRC*PRIO_W-1:0] prio_flat;
   logic [NUM_SRC-1:0]        pend;
   logic [VEC_W-1:0]          pick_vec;
   logic                      pick_ok;
   logic                      clr_all;
   logic                      gen_q;
   logic [VEC_W-1:0]          vec_q;
   logic                      irq_q;

   assign clr_all = wr.rst && reg_wdata[0];

   vic_regif #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W),
      .VEC_W(VEC_W), .IDX_W(IDX_W)
   ) u_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (reg_sel),
      .we        (reg_we),
      .addr      (reg_addr),
      .en_mask   (en_mask),
      .edge_mode (edge_mode),
      .prio_flat (prio_flat),
      .cur_vec   (vec_q),
      .gen_en    (gen_q),
      .wr        (wr),
      .wr_grp    (wr_grp),
      .setup_idx (setup_idx),
      .rdata     (reg_rdata)
   );

   vic_src_bank #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .IDX_W(IDX_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_all   (clr_all),
      .irq_src   (irq_src),
      .ena_wr    (wr.ena),
      .dis_wr    (wr.dis),
      .eoi_wr    (wr.eoi),
      .setup_wr  (wr.setup),
      .wr_grp    (wr_grp),
      .setup_idx (setup_idx),
      .wdata     (reg_wdata),
      .cur_vec   (vec_q),
      .en_mask   (en_mask),
      .edge_mode (edge_mode),
      .prio_flat (prio_flat),
      .pend      (pend)
   );

   vic_prio_pick #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)
   ) u_pick (
      .req       (en_mask & pend),
      .prio_flat (prio_flat),
      .vec       (pick_vec),
      .valid     (pick_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || clr_all) begin
         gen_q <= 1'b0;
         vec_q <= VEC_W'(NUM_SRC);
         irq_q <= 1'b0;
      end else begin
         if (wr.gen) gen_q <= reg_wdata[0];
         vec_q <= pick_vec;
         irq_q <= gen_q && pick_ok;
      end
   end

   assign cpu_irq = irq_q;
   assign cpu_vec = vec_q;

endmodule

// File: rtl/vic64_ctrl_chk.sv
module vic64_ctrl_chk #(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned ADDR_W  = 11,
   parameter int unsigned VEC_W   = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_sel,
   input logic               reg_we,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [31:0]        reg_wdata,
   input logic [31:0]        reg_rdata,
   input logic               cpu_irq,
   input logic [VEC_W-1:0]   cpu_vec,
   input logic [NUM_SRC-1:0] en_mask,
   input logic               gen_en
);

   logic wr_ena0, wr_dis0, rd_vec, wr_rst;

   assign wr_ena0 = reg_sel && reg_we  && reg_addr == ADDR_W'(vic_pkg::WI_ENA << 3);
   assign wr_dis0 = reg_sel && reg_we  && reg_addr == ADDR_W'(vic_pkg::WI_DIS << 3);
   assign rd_vec  = reg_sel && !reg_we && reg_addr == ADDR_W'(vic_pkg::WI_VEC << 3);
   assign wr_rst  = reg_sel && reg_we  && reg_addr == ADDR_W'(vic_pkg::WI_RST << 3)
                 && reg_wdata[0];

   a_r2_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ena0 |=> ((en_mask[31:0] & $past(reg_wdata)) == $past(reg_wdata)));

   a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dis0 |=> ((en_mask[31:0] & $past(reg_wdata)) == 32'd0));

   a_r7_irq_needs_gen: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> $past(gen_en));

   a_r8_irq_vec_valid: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> (cpu_vec < VEC_W'(NUM_SRC)));

   a_r8_vec_readback: assert property (@(posedge clk) disable iff (!rst_n)
      rd_vec |=> (reg_rdata == 32'($past(cpu_vec))));

   a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rst |=> (!cpu_irq && cpu_vec == VEC_W'(NUM_SRC) && en_mask == '0 && !gen_en));

endmodule

bind vic64_ctrl vic64_ctrl_chk #(
   .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .VEC_W(VEC_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_sel   (reg_sel),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .cpu_irq   (cpu_irq),
   .cpu_vec   (cpu_vec),
   .en_mask   (en_mask),
   .gen_en    (gen_q)
);

// File: tb/vic64_ctrl_tb_top.sv
`timescale 1ns/1ps
module vic64_ctrl_tb_top;

   localparam int N = 64;
   localparam int A_ENA_LO = 'h000, A_ENA_HI = 'h008, A_DIS_LO = 'h020, A_DIS_HI = 'h028;
   localparam int A_VEC = 'h040, A_EOI = 'h048, A_RST = 'h050, A_GEN = 'h058, A_SET = 'h400;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] irq_src = '0;
   logic        reg_sel = 1'b0, reg_we = 1'b0;
   logic [10:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        cpu_irq;
   logic [6:0]  cpu_vec;

   int checks = 0, fails = 0;
   bit done = 0;

   always #10 clk = ~clk;

   vic64_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
      .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cpu_irq(cpu_irq), .cpu_vec(cpu_vec)
   );

   // ---------------- behavioural reference ----------------
   bit   m_en[N], m_edge[N], m_lat[N], m_smp[N];
   int   m_prio[N];
   bit   m_gen, m_irq;
   int   m_vec;
   logic [31:0] m_rd;

   task automatic m_clear();
      for (int i = 0; i < N; i++) begin
         m_en[i] = 0; m_edge[i] = 0; m_lat[i] = 0; m_smp[i] = 0; m_prio[i] = 0;
      end
      m_gen = 0; m_irq = 0; m_vec = N; m_rd = '0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) m_clear();
      else begin
         int best, bp, a, nv;
         bit ni, rd, wr;
         bit nlat[N];
         logic [31:0] rv;
         best = -1; bp = -1;
         for (int i = 0; i < N; i++) begin
            bit p;
            p = m_edge[i] ? m_lat[i] : m_smp[i];
            if (m_en[i] && p && m_prio[i] > bp) begin best = i; bp = m_prio[i]; end
         end
         nv = (best < 0) ? N : best;
         ni = m_gen && (best >= 0);
         a  = int'(reg_addr);
         rd = reg_sel && !reg_we && (a % 8 == 0);
         wr = reg_sel && reg_we && (a % 8 == 0);
         rv = '0;
         if (a >= A_SET) begin
            if ((a - A_SET) / 8 < N)
               rv = 32'(m_prio[(a - A_SET) / 8]) | (32'(m_edge[(a - A_SET) / 8]) << 16);
         end else if (a < 16 || (a >= A_DIS_LO && a < A_DIS_LO + 16)) begin
            for (int b = 0; b < 32; b++) rv[b] = m_en[((a % 32) / 8) * 32 + b];
         end else if (a == A_VEC) rv = 32'(m_vec);
         else if (a == A_GEN) rv = 32'(m_gen);
         for (int i = 0; i < N; i++) begin
            bit kill;
            kill = (wr && a == A_EOI && m_vec == i)
                || (wr && a == A_SET + i * 8 && !reg_wdata[16]);
            nlat[i] = (m_edge[i] && irq_src[i] && !m_smp[i]) || (m_lat[i] && !kill);
         end
         for (int i = 0; i < N; i++) begin
            m_lat[i] = nlat[i];
            m_smp[i] = irq_src[i];
         end
         if (wr) begin
            if (a < 16)
               for (int b = 0; b < 32; b++) begin
                  if (reg_wdata[b]) m_en[(a / 8) * 32 + b] = 1;
               end
            if (a >= A_DIS_LO && a < A_DIS_LO + 16)
               for (int b = 0; b < 32; b++) begin
                  if (reg_wdata[b]) m_en[((a - A_DIS_LO) / 8) * 32 + b] = 0;
               end
            if (a >= A_SET && (a - A_SET) / 8 < N) begin
               m_edge[(a - A_SET) / 8] = reg_wdata[16];
               m_prio[(a - A_SET) / 8] = int'(reg_wdata[3:0]);
            end
         end
         m_rd  = rd ? rv : '0;
         m_vec = nv;
         m_irq = ni;
         if (wr && a == A_GEN) m_gen = reg_wdata[0];
         if (wr && a == A_RST && reg_wdata[0]) m_clear();
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // compare against the reference on every clock, after the edge settles
   always @(posedge clk) begin
      #5;
      if (rst_n && !done) begin
         check("R6", 32'(cpu_vec), 32'(m_vec), "model vector");
         check("R7", 32'(cpu_irq), 32'(m_irq), "model irq");
         check("R8", reg_rdata, m_rd, "model read data");
      end
   end

   // ---------------- stimulus ----------------
   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_wr(int addr, logic [31:0] data);
      @(negedge clk);
      reg_sel = 1; reg_we = 1; reg_addr = 11'(addr); reg_wdata = data;
      @(negedge clk);
      reg_sel = 0; reg_we = 0;
   endtask

   task automatic bus_rd(int addr, output logic [31:0] data);
      @(negedge clk);
      reg_sel = 1; reg_we = 0; reg_addr = 11'(addr);
      @(negedge clk);
      reg_sel = 0;
      data = reg_rdata;
   endtask

   task automatic pulse(int src);
      @(negedge clk); irq_src[src] = 1;
      @(negedge clk); irq_src[src] = 0;
   endtask

   task automatic see(string tag, int vec, int irq);
      tick(3);
      check(tag, 32'(cpu_vec), 32'(vec), "vector");
      if (irq >= 0) check(tag, 32'(cpu_irq), 32'(irq), "irq");
   endtask

   initial begin
      #4_000_000;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [31:0] d;
      tick(3);
      rst_n = 1;
      tick(2);
      // R1 reset state
      check("R1", 32'(cpu_vec), 64, "vector after reset");
      check("R1", 32'(cpu_irq), 0, "irq after reset");
      bus_rd(A_ENA_HI, d); check("R1", d, 0, "enable mask");
      bus_rd(A_SET + 5 * 8, d); check("R1", d, 0, "setup word");
      // R2 / R3 enable and disable
      bus_wr(A_ENA_LO, 32'h0000_00F0);
      bus_wr(A_ENA_LO, 32'h0000_0001);
      bus_rd(A_ENA_LO, d); check("R2", d, 32'h0000_00F1, "low enables");
      bus_wr(A_ENA_HI, 32'h8000_0001);
      bus_rd(A_DIS_HI, d); check("R2", d, 32'h8000_0001, "high mask via disable addr");
      bus_wr(A_DIS_LO, 32'h0000_0010);
      bus_rd(A_ENA_LO, d); check("R3", d, 32'h0000_00E1, "after disable");
      // R7 generation gate, R8 vector read
      @(negedge clk); irq_src[5] = 1;
      see("R7", 5, 0);
      bus_rd(A_VEC, d); check("R8", d, 5, "vector register");
      bus_wr(A_GEN, 32'h1);
      tick(2); check("R7", 32'(cpu_irq), 1, "irq with generation on");
      // R4 level drop
      @(negedge clk); irq_src[5] = 0;
      see("R4", 64, 0);
      // R6 priority and tie
      bus_wr(A_SET + 32 * 8, 32'h3);
      bus_wr(A_SET + 63 * 8, 32'h9);
      bus_rd(A_SET + 63 * 8, d); check("R6", d, 32'h9, "setup readback");
      @(negedge clk); irq_src[6] = 1; irq_src[7] = 1; irq_src[32] = 1;
      see("R6", 32, 1);
      @(negedge clk); irq_src[63] = 1;
      see("R6", 63, 1);
      @(negedge clk); irq_src[63] = 0;
      bus_wr(A_SET + 7 * 8, 32'h3);
      see("R6", 7, 1);
      @(negedge clk); irq_src = '0;
      see("R8", 64, 0);
      // R5 edge latch, R9 EOI, R10 setup rewrite
      bus_wr(A_SET, 32'h0001_0001);
      pulse(0);
      see("R5", 0, 1);
      bus_wr(A_EOI, 32'h0);
      see("R9", 64, 0);
      pulse(0);
      see("R5", 0, 1);
      bus_wr(A_SET, 32'h0000_0001);
      bus_wr(A_SET, 32'h0001_0001);
      see("R10", 64, 0);
      // R13 latched while disabled
      bus_wr(A_DIS_LO, 32'h1);
      pulse(0);
      see("R13", 64, 0);
      bus_wr(A_ENA_LO, 32'h1);
      see("R13", 0, 1);
      bus_wr(A_EOI, 32'h0);
      see("R9", 64, 0);
      // R12 rise coincident with EOI
      pulse(0);
      see("R12", 0, 1);
      @(negedge clk);
      irq_src[0] = 1; reg_sel = 1; reg_we = 1; reg_addr = 11'(A_EOI); reg_wdata = 0;
      @(negedge clk); reg_sel = 0; reg_we = 0;
      see("R12", 0, 1);
      bus_wr(A_EOI, 32'h0);
      see("R12", 64, 0);
      @(negedge clk); irq_src[0] = 0;
      // R11 soft reset
      @(negedge clk); irq_src[5] = 1;
      see("R11", 5, 1);
      bus_wr(A_RST, 32'h1);
      check("R11", 32'(cpu_vec), 64, "vector after soft reset");
      check("R11", 32'(cpu_irq), 0, "irq after soft reset");
      bus_rd(A_ENA_LO, d); check("R11", d, 0, "enables cleared");
      bus_rd(A_GEN, d); check("R11", d, 0, "generation cleared");
      bus_rd(A_SET + 63 * 8, d); check("R11", d, 0, "setup cleared");
      see("R11", 64, 0);
      @(negedge clk); irq_src = '0;
      tick(2);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule